// File: doc/BRIEF.md
# Dual-Input Fan PWM Controller

This block turns two unsigned control codes, typically temperature readings from a converter, into a fan-drive pulse-width signal. The larger of the two codes sets the duty cycle through a configurable linear ramp between a low point (fan off) and a high point (fan fully on). The pulse train has a period of 256 time-base ticks. A new duty value takes effect only when a period wraps, so a code change never produces a runt pulse.

When both codes fall below a sleep level, the controller parks the fan at 0% duty. It stays parked until one code climbs above the sleep level plus a wake margin. Every wake, and every reset, starts a kick phase that holds the drive fully on for 64 time-base ticks so that a stalled fan can spin up. After the kick, normal duty tracking resumes from the start of a fresh period.

An active-low fault flag reports whether either code is above an overtemperature level. It is combinational on the codes and ignores the run, sleep and kick phases. The time-base enable lets a slow external tick pace both the PWM counter and the kick timer.

Top module: `fan_duty_ctrl`

## Requirements
- R1: The duty cycle is set by the larger of codeA and codeB; swapping the two codes gives the same duty, and control passes between them without any other change of state.
- R2: With m the larger code, the drive is high for 0 of 256 ticks when m <= lowPoint, for all 256 ticks when m >= highPoint, and otherwise for floor((m - lowPoint) * 256 / (highPoint - lowPoint)) ticks per period.
- R3: The period is 256 enabled ticks. A counter runs from 0 to 255 and the drive is high while the count is below the loaded duty. A new duty is loaded only when the count wraps from 255 to 0, or when a kick phase ends.
- R4: While running, if both codes are strictly below sleepLevel, the controller sleeps from the next clock and holds the drive low.
- R5: A sleeping controller wakes only when a code is strictly greater than sleepLevel + wakeMargin, computed without overflow. Codes at or below that sum keep it asleep.
- R6: A kick phase holds the drive high for exactly 64 enabled ticks. Normal tracking then starts with the period counter at 0 and a freshly loaded duty.
- R7: Only cycles with tickEn high advance the period counter and the kick timer. With tickEn low, a kick phase never ends.
- R8: faultN is low exactly when codeA or codeB is strictly greater than overLevel, whatever the sleep or kick phase.
- R9: A synchronous active-high rst puts the controller in the kick phase, so the drive is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Time-base enable; one PWM tick per high cycle |
| codeA | input | 8 | First control code |
| codeB | input | 8 | Second control code |
| lowPoint | input | 8 | Code at or below which duty is 0% |
| highPoint | input | 8 | Code at or above which duty is 100% |
| sleepLevel | input | 8 | Both codes below this put the controller to sleep |
| wakeMargin | input | 8 | Hysteresis added to sleepLevel for waking |
| overLevel | input | 8 | Overtemperature level for the fault flag |
| pwmOut | output | 1 | Fan drive pulse train |
| faultN | output | 1 | Active-low overtemperature flag |

## Verification
Duty tracking is tried with code pairs presented in both orders. This shows that the larger code rules and not one fixed input. One pair has one code below the sleep level and the other high, which shows that sleep needs both codes low. Codes just above the low point, mid-ramp and just below the high point check the rounding of the linear map, and a code at the high point checks saturation. The sleep and wake sequence steps a code through the sleep level, the wake sum itself and one above it to separate a strict threshold from an inclusive one. A code change in the middle of a period checks that the new duty waits for the period wrap.

// File: rtl/fan_pkg.sv
`timescale 1ns/1ps
package fan_pkg;
  typedef enum logic [1:0] {
    MODE_KICK  = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_SLEEP = 2'd2
  } fanMode_t;

  typedef struct packed {
    logic restart;   // kick finished: zero period counter and load duty
    logic forceOn;   // drive held high
    logic forceOff;  // drive held low
  } ctlStrobe_t;
endpackage

// File: rtl/fan_ctl.sv
`timescale 1ns/1ps
module fan_ctl #(
  parameter int CODE_W     = 8,
  parameter int KICK_TICKS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic [CODE_W-1:0]   codeA,
  input  logic [CODE_W-1:0]   codeB,
  input  logic [CODE_W-1:0]   sleepLevel,
  input  logic [CODE_W-1:0]   wakeMargin,
  output fan_pkg::ctlStrobe_t strobe,
  output fan_pkg::fanMode_t   mode
);
  import fan_pkg::*;

  localparam int KW = $clog2(KICK_TICKS + 1);
  localparam logic [KW-1:0] KICK_LAST = KW'(KICK_TICKS - 1);

  logic [KW-1:0]   kickCnt;
  logic [CODE_W:0] wakeLevel;
  logic            bothLow;
  logic            anyHigh;
  logic            kickDone;

  assign wakeLevel = {1'b0, sleepLevel} + {1'b0, wakeMargin};
  assign bothLow   = (codeA < sleepLevel) && (codeB < sleepLevel);
  assign anyHigh   = ({1'b0, codeA} > wakeLevel) || ({1'b0, codeB} > wakeLevel);
  assign kickDone  = (mode == MODE_KICK) && tickEn && (kickCnt == KICK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_KICK;
      kickCnt <= '0;
    end else begin
      case (mode)
        MODE_KICK: begin
          if (kickDone) begin
            mode    <= MODE_RUN;
            kickCnt <= '0;
          end else if (tickEn) begin
            kickCnt <= kickCnt + 1'b1;
          end
        end
        MODE_RUN: begin
          if (bothLow) mode <= MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (anyHigh) begin
            mode    <= MODE_KICK;
            kickCnt <= '0;
          end
        end
        default: begin
          mode    <= MODE_KICK;
          kickCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.restart  = kickDone;
    strobe.forceOn  = (mode == MODE_KICK);
    strobe.forceOff = (mode == MODE_SLEEP);
  end
endmodule

// File: rtl/fan_dp.sv
`timescale 1ns/1ps
module fan_dp #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  fan_pkg::ctlStrobe_t strobe,
  input  logic [CODE_W-1:0]   codeA,
  input  logic [CODE_W-1:0]   codeB,
  input  logic [CODE_W-1:0]   lowPoint,
  input  logic [CODE_W-1:0]   highPoint,
  input  logic [CODE_W-1:0]   overLevel,
  output logic                pwmOut,
  output logic                faultN
);
  localparam int DUTY_W = CNT_W + 1;
  localparam int PROD_W = CODE_W + CNT_W;
  localparam logic [CNT_W-1:0]  CNT_LAST  = '1;
  localparam logic [DUTY_W-1:0] DUTY_FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CODE_W-1:0] maxCode;
  logic [CODE_W-1:0] span;
  logic [CODE_W-1:0] offs;
  logic [PROD_W-1:0] scaled;
  logic [DUTY_W-1:0] dutyNext;
  logic [DUTY_W-1:0] dutyReg;
  logic [CNT_W-1:0]  cnt;
  logic              pwmRaw;

  assign maxCode = (codeA >= codeB) ? codeA : codeB;

  always_comb begin
    span   = highPoint - lowPoint;
    offs   = maxCode - lowPoint;
    scaled = {offs, {CNT_W{1'b0}}} / {{CNT_W{1'b0}}, span};
    if (maxCode >= highPoint)      dutyNext = DUTY_FULL;
    else if (maxCode <= lowPoint)  dutyNext = '0;
    else                           dutyNext = scaled[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dutyReg <= '0;
    end else if (strobe.restart) begin
      cnt     <= '0;
      dutyReg <= dutyNext;
    end else if (tickEn) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_LAST) dutyReg <= dutyNext;
    end
  end

  assign pwmRaw = ({1'b0, cnt} < dutyReg);
  assign pwmOut = strobe.forceOn | (~strobe.forceOff & pwmRaw);
  assign faultN = ~((codeA > overLevel) || (codeB > overLevel));
endmodule

// File: rtl/fan_duty_ctrl.sv
`timescale 1ns/1ps
module fan_duty_ctrl #(
  parameter int CODE_W     = 8,
  parameter int CNT_W      = 8,
  parameter int KICK_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  input  logic [CODE_W-1:0] lowPoint,
  input  logic [CODE_W-1:0] highPoint,
  input  logic [CODE_W-1:0] sleepLevel,
  input  logic [CODE_W-1:0] wakeMargin,
  input  logic [CODE_W-1:0] overLevel,
  output logic              pwmOut,
  output logic              faultN
);
  import fan_pkg::*;

  ctlStrobe_t strobe;
  fanMode_t   mode;

  fan_ctl #(.CODE_W(CODE_W), .KICK_TICKS(KICK_TICKS)) ctl_i (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .codeA(codeA), .codeB(codeB),
    .sleepLevel(sleepLevel), .wakeMargin(wakeMargin),
    .strobe(strobe), .mode(mode)
  );

  fan_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .strobe(strobe),
    .codeA(codeA), .codeB(codeB),
    .lowPoint(lowPoint), .highPoint(highPoint), .overLevel(overLevel),
    .pwmOut(pwmOut), .faultN(faultN)
  );
endmodule

// File: rtl/fan_duty_chk.sv
`timescale 1ns/1ps
module fan_duty_chk #(
  parameter int CODE_W     = 8,
  parameter int KICK_TICKS = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic [CODE_W-1:0] codeA,
  input logic [CODE_W-1:0] codeB,
  input logic [CODE_W-1:0] sleepLevel,
  input logic [CODE_W-1:0] wakeMargin,
  input logic [CODE_W-1:0] overLevel,
  input logic              pwmOut,
  input logic              faultN,
  input fan_pkg::fanMode_t mode
);
  import fan_pkg::*;

  localparam int KW = $clog2(KICK_TICKS + 1);
  logic [KW-1:0]   seenTicks;
  logic [CODE_W:0] wakeSum;

  assign wakeSum = {1'b0, sleepLevel} + {1'b0, wakeMargin};

  always_ff @(posedge clk) begin
    if (rst || mode != MODE_KICK) seenTicks <= '0;
    else if (tickEn)              seenTicks <= seenTicks + 1'b1;
  end

  a_r9_kick_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == MODE_KICK) && pwmOut);

  a_r6_kick_drive_high: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_KICK) |-> pwmOut);

  a_r6_kick_bounded: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_KICK) |-> (seenTicks < KW'(KICK_TICKS)));

  a_r6_kick_ends: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_KICK && tickEn && seenTicks == KW'(KICK_TICKS - 1)) |=> (mode == MODE_RUN));

  a_r7_kick_stalls: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_KICK && !tickEn) |=> (mode == MODE_KICK));

  a_r4_sleep_low: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP) |-> !pwmOut);

  a_r4_enter_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && codeA < sleepLevel && codeB < sleepLevel) |=> (mode == MODE_SLEEP));

  a_r5_hold_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP && {1'b0, codeA} <= wakeSum && {1'b0, codeB} <= wakeSum)
      |=> (mode == MODE_SLEEP));

  a_r5_wake: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP && ({1'b0, codeA} > wakeSum || {1'b0, codeB} > wakeSum))
      |=> (mode == MODE_KICK));

  a_r8_fault_set: assert property (@(posedge clk) disable iff (rst)
    (codeA > overLevel || codeB > overLevel) |-> !faultN);

  a_r8_fault_clear: assert property (@(posedge clk) disable iff (rst)
    (codeA <= overLevel && codeB <= overLevel) |-> faultN);
endmodule

bind fan_duty_ctrl fan_duty_chk #(.CODE_W(CODE_W), .KICK_TICKS(KICK_TICKS)) chk_i (
  .clk(clk), .rst(rst), .tickEn(tickEn),
  .codeA(codeA), .codeB(codeB),
  .sleepLevel(sleepLevel), .wakeMargin(wakeMargin), .overLevel(overLevel),
  .pwmOut(pwmOut), .faultN(faultN), .mode(mode)
);

// File: tb/fan_duty_ctrl_test.sv
`timescale 1ns/1ps
module fan_duty_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b1;
  logic [7:0] codeA = 8'd35, codeB = 8'd35;
  logic [7:0] lowPoint = 8'd40, highPoint = 8'd200;
  logic [7:0] sleepLevel = 8'd30, wakeMargin = 8'd10, overLevel = 8'd220;
  logic       pwmOut, faultN;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fan_duty_ctrl uut (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .codeA(codeA), .codeB(codeB),
    .lowPoint(lowPoint), .highPoint(highPoint),
    .sleepLevel(sleepLevel), .wakeMargin(wakeMargin), .overLevel(overLevel),
    .pwmOut(pwmOut), .faultN(faultN)
  );

  // {codeA, codeB, expected high ticks per 256}; low 40, high 200
  localparam int NVEC = 10;
  localparam logic [24:0] VEC [NVEC] = '{
    {8'd120, 8'd50,  9'd128},
    {8'd50,  8'd120, 9'd128},
    {8'd100, 8'd60,  9'd96},
    {8'd0,   8'd200, 9'd256},
    {8'd150, 8'd5,   9'd176},
    {8'd45,  8'd35,  9'd8},
    {8'd40,  8'd41,  9'd1},
    {8'd180, 8'd181, 9'd225},
    {8'd199, 8'd10,  9'd254},
    {8'd38,  8'd40,  9'd0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic countHigh(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) c++;
      step();
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    #1;
    // R9 / R6: reset enters kick, 64 ticks high, then duty 0 (codes 35 <= low 40)
    doReset();
    check("R9 reset drive high", int'(pwmOut), 1);
    countHigh(64, c);
    check("R6 kick length after reset", c, 64);
    check("R6 after kick duty zero", int'(pwmOut), 0);

    // R7: kick stalls with tickEn low; R8 fault during kick
    tickEn = 1'b0;
    doReset();
    countHigh(200, c);
    check("R7 kick held without ticks", c, 200);
    codeA = 8'd221; #1;
    check("R8 fault in kick", int'(faultN), 0);
    check("R8 kick unaffected", int'(pwmOut), 1);
    codeA = 8'd35; #1;
    check("R8 fault clear", int'(faultN), 1);
    tickEn = 1'b1;
    countHigh(64, c);
    check("R7 kick ends after 64 ticks", c, 64);
    check("R7 drive low after kick", int'(pwmOut), 0);

    // R1/R2 table: duty follows larger code through linear map
    for (int v = 0; v < NVEC; v++) begin
      codeA = VEC[v][24:17];
      codeB = VEC[v][16:9];
      repeat (300) step();
      countHigh(256, c);
      check($sformatf("R1/R2 vector %0d duty", v), c, int'(VEC[v][8:0]));
    end

    // R4: both below sleep level -> sleep, drive low
    codeA = 8'd20; codeB = 8'd25;
    step();
    countHigh(300, c);
    check("R4 sleep holds drive low", c, 0);
    check("R8 no fault while asleep", int'(faultN), 1);

    // R5: wake needs code strictly above 30+10
    codeA = 8'd38;
    countHigh(100, c);
    check("R5 no wake at 38", c, 0);
    codeA = 8'd40;
    countHigh(100, c);
    check("R5 no wake at wake sum 40", c, 0);
    codeA = 8'd41;
    step();
    countHigh(64, c);
    check("R5/R6 wake kick length", c, 64);

    // R3: period starts at 0 with duty 1; mid-period change waits for wrap
    c = 0;
    for (int j = 0; j < 256; j++) begin
      if (pwmOut) c++;
      if (j == 100) begin codeA = 8'd120; codeB = 8'd20; end
      step();
    end
    check("R3 duty held until wrap", c, 1);
    countHigh(256, c);
    check("R3 new duty after wrap", c, 128);

    // R8: fault in run, strict threshold
    codeB = 8'd230; #1;
    check("R8 fault on codeB", int'(faultN), 0);
    codeA = 8'd220; codeB = 8'd220; #1;
    check("R8 no fault at level", int'(faultN), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule